// File: doc/BRIEF.md
# Speculative L1 Line State Tracker

This block keeps the speculation bookkeeping for every line of one processor's primary data cache while that processor runs a speculative thread. Each line carries a valid flag, a dirty-during-speculation flag (here called `mod`), a deferred-invalidate flag (`pre`) and two per-word masks. The read mask records words the thread consumed from outside. The written mask records words the thread produced itself, which renames those words. Local loads, local stores and line fills update this state. Stores seen on the shared write bus carry the writer's speculation rank, and the block compares that rank with its own.

When an older (less speculative) writer stores to a word this thread has already read, the block raises a one-cycle violation request for the exception logic. Thread-level commands act on every line in a single cycle. Restart throws away lines the thread dirtied. Completion drops lines that younger writers touched. Start and completion wipe the per-word masks. Evicting a line whose reads are still being watched makes the block request a stall, which holds until this processor becomes the non-speculative head. Data storage and tag matching sit outside: callers present line indices that already hit.

Top module: `spec_line_tracker`

## Requirements
- R1: A load to word w of a valid line sets that word's read bit, unless the word's written bit is already set. The read bit is observed through R2.
- R2: A bus store with a rank numerically lower than `my_rank` (a lower value means less speculative) is an older writer. If it targets a valid line at a word whose read bit is set, `viol_req` is high for exactly one cycle, on the cycle after the store. Equal or higher ranks, clear read bits and invalid lines never raise it.
- R3: A full-word store (`st_full`=1) sets the word's written bit, so later loads of that word set no read bit. A partial store (`st_full`=0) sets no written bit.
- R4: A store to a line that already has any read bit set does not set a written bit. A word never has both bits set.
- R5: A fill makes the line valid, clears its masks and its `pre` flag, and sets its `mod` flag from `fill_spec`. Any local store to a valid line sets `mod`.
- R6: `thr_restart` invalidates every line whose `mod` flag is set, keeps the other lines valid, and clears all read bits, written bits and `mod` flags.
- R7: A bus store with a rank higher than `my_rank` sets the target line's `pre` flag and leaves the line valid. `thr_complete` invalidates every line with `pre` set.
- R8: `thr_start` and `thr_complete` clear every read and written bit of every line in one cycle.
- R9: An eviction (`ev_valid`) invalidates the line. If the line had a read bit set while `is_head` was low, `stall_req` goes high on the next cycle. It stays high until a cycle in which `is_head` is sampled high, and is low on the cycle after that.
- R10: In a cycle with any of `thr_start`, `thr_restart`, `thr_complete` high, loads, stores, fills, bus stores and evictions are ignored and raise no violation. Restart has priority over complete, and complete has priority over start.
- R11: After reset, every line is invalid and `viol_req` and `stall_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_rank | input | RANK_W | Speculation rank of this processor's thread |
| is_head | input | 1 | This processor runs the non-speculative thread |
| thr_start | input | 1 | New thread begins |
| thr_restart | input | 1 | Current thread is squashed and re-runs |
| thr_complete | input | 1 | Current thread commits |
| ld_valid | input | 1 | Local load hit |
| ld_line | input | LINE_W | Line of the load |
| ld_word | input | WORD_W | Word within the line |
| st_valid | input | 1 | Local store hit |
| st_line | input | LINE_W | Line of the store |
| st_word | input | WORD_W | Word within the line |
| st_full | input | 1 | Store covers the whole word |
| fill_valid | input | 1 | Line fill |
| fill_line | input | LINE_W | Line being filled |
| fill_spec | input | 1 | Fill data came from speculative buffers |
| snp_valid | input | 1 | Bus store hit in this cache |
| snp_line | input | LINE_W | Line hit by the bus store |
| snp_word | input | WORD_W | Word hit by the bus store |
| snp_rank | input | RANK_W | Rank of the bus writer |
| ev_valid | input | 1 | Line eviction |
| ev_line | input | LINE_W | Evicted line |
| line_valid | output | NUM_LINES | Valid flag of each line |
| viol_req | output | 1 | True-dependence violation request |
| stall_req | output | 1 | Halt request until head |

## Verification
The bench runs short scenarios through the read and written masks. A design that let a full store rename a word after that line was already read would miss the violation the bench expects. A design that treated partial stores as renaming would miss one too, and so would a design that fired on equal or younger ranks. The gang tests mix dirty, clean, speculatively filled and younger-written lines and check the exact `line_valid` pattern after restart and after completion. A tracker that invalidated on the wrong flag, or invalidated deferred lines early, shows a wrong pattern there. Further tests send a bus store in the same cycle as a gang command, and hold a stall across several non-head cycles. A missing command gate would fire a violation in the first case. A stall that cleared early or never cleared would show up in the second.

// File: rtl/spec_trk_pkg.sv
package spec_trk_pkg;

  typedef enum logic [1:0] {
    GANG_NONE,
    GANG_START,
    GANG_RESTART,
    GANG_COMPLETE
  } gang_e;

  // Lower rank value means an older, less speculative thread.
  function automatic logic rank_older(input int unsigned writer, input int unsigned self);
    return writer < self;
  endfunction

  function automatic logic rank_younger(input int unsigned writer, input int unsigned self);
    return writer > self;
  endfunction

  // Restart beats complete, complete beats start.
  function automatic gang_e pick_gang(input logic st, input logic rs, input logic cp);
    if (rs) return GANG_RESTART;
    if (cp) return GANG_COMPLETE;
    if (st) return GANG_START;
    return GANG_NONE;
  endfunction

endpackage

// File: rtl/spec_line.sv
module spec_line
  import spec_trk_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gang_e             gang,
  input  logic              ld_hit,
  input  logic [WORD_W-1:0] ld_word,
  input  logic              st_hit,
  input  logic [WORD_W-1:0] st_word,
  input  logic              st_full,
  input  logic              fill_hit,
  input  logic              fill_spec,
  input  logic              snp_hit,
  input  logic [WORD_W-1:0] snp_word,
  input  logic              snp_older,
  input  logic              snp_younger,
  input  logic              ev_hit,
  output logic              valid_o,
  output logic              rd_any_o,
  output logic              viol_o
);

  logic             valid_q, mod_q, pre_q;
  logic [WORDS-1:0] rd_q, wr_q;
  logic             valid_n, mod_n, pre_n;
  logic [WORDS-1:0] rd_n, wr_n;

  always_comb begin
    valid_n = valid_q;
    mod_n   = mod_q;
    pre_n   = pre_q;
    rd_n    = rd_q;
    wr_n    = wr_q;
    case (gang)
      GANG_RESTART: begin
        if (mod_q) valid_n = 1'b0;
        rd_n  = '0;
        wr_n  = '0;
        mod_n = 1'b0;
      end
      GANG_COMPLETE: begin
        if (pre_q) valid_n = 1'b0;
        rd_n  = '0;
        wr_n  = '0;
        mod_n = 1'b0;
        pre_n = 1'b0;
      end
      GANG_START: begin
        rd_n = '0;
        wr_n = '0;
      end
      default: begin
        if (ev_hit) begin
          valid_n = 1'b0;
          mod_n   = 1'b0;
          pre_n   = 1'b0;
          rd_n    = '0;
          wr_n    = '0;
        end else if (fill_hit) begin
          valid_n = 1'b1;
          mod_n   = fill_spec;
          pre_n   = 1'b0;
          rd_n    = '0;
          wr_n    = '0;
        end else if (valid_q) begin
          if (ld_hit && !wr_q[ld_word]) rd_n[ld_word] = 1'b1;
          if (st_hit) begin
            mod_n = 1'b1;
            if (st_full && rd_n == '0) wr_n[st_word] = 1'b1;
          end
          if (snp_hit && snp_younger) pre_n = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mod_q   <= 1'b0;
      pre_q   <= 1'b0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else begin
      valid_q <= valid_n;
      mod_q   <= mod_n;
      pre_q   <= pre_n;
      rd_q    <= rd_n;
      wr_q    <= wr_n;
    end
  end

  assign valid_o  = valid_q;
  assign rd_any_o = |rd_q;
  assign viol_o   = valid_q && snp_hit && snp_older && rd_q[snp_word];

  AST_RD_WR_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q & wr_q) == '0); // R4
  AST_RESTART_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (gang == GANG_RESTART && mod_q) |=> !valid_q); // R6
  AST_COMPLETE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (gang == GANG_COMPLETE && pre_q) |=> !valid_q); // R7
  AST_GANG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (gang == GANG_START || gang == GANG_COMPLETE) |=> (rd_q == '0 && wr_q == '0)); // R8

endmodule

// File: rtl/spec_stall_ctl.sv
module spec_stall_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_req,
  input  logic is_head,
  output logic stall_o
);

  logic stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       stall_q <= 1'b0;
    else if (is_head) stall_q <= 1'b0;
    else if (ev_req)  stall_q <= 1'b1;
  end

  assign stall_o = stall_q;

  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    is_head |=> !stall_o); // R9
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_o) |-> $past(ev_req)); // R9

endmodule

// File: rtl/spec_line_tracker.sv
module spec_line_tracker
  import spec_trk_pkg::*;
#(
  parameter int NUM_LINES      = 8,
  parameter int WORDS_PER_LINE = 4,
  parameter int RANK_W         = 3,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int WORD_W = $clog2(WORDS_PER_LINE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RANK_W-1:0]    my_rank,
  input  logic                 is_head,
  input  logic                 thr_start,
  input  logic                 thr_restart,
  input  logic                 thr_complete,
  input  logic                 ld_valid,
  input  logic [LINE_W-1:0]    ld_line,
  input  logic [WORD_W-1:0]    ld_word,
  input  logic                 st_valid,
  input  logic [LINE_W-1:0]    st_line,
  input  logic [WORD_W-1:0]    st_word,
  input  logic                 st_full,
  input  logic                 fill_valid,
  input  logic [LINE_W-1:0]    fill_line,
  input  logic                 fill_spec,
  input  logic                 snp_valid,
  input  logic [LINE_W-1:0]    snp_line,
  input  logic [WORD_W-1:0]    snp_word,
  input  logic [RANK_W-1:0]    snp_rank,
  input  logic                 ev_valid,
  input  logic [LINE_W-1:0]    ev_line,
  output logic [NUM_LINES-1:0] line_valid,
  output logic                 viol_req,
  output logic                 stall_req
);

  gang_e                gang;
  logic                 quiet;
  logic                 snp_older, snp_younger;
  logic [NUM_LINES-1:0] viol_vec, rd_any_vec;
  logic                 viol_q;
  logic                 ev_req;

  assign gang        = pick_gang(thr_start, thr_restart, thr_complete);
  assign quiet       = (gang == GANG_NONE);
  assign snp_older   = rank_older(int'(snp_rank), int'(my_rank));
  assign snp_younger = rank_younger(int'(snp_rank), int'(my_rank));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    spec_line #(.WORDS(WORDS_PER_LINE)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .gang       (gang),
      .ld_hit     (ld_valid && ld_line == LINE_W'(g)),
      .ld_word    (ld_word),
      .st_hit     (st_valid && st_line == LINE_W'(g)),
      .st_word    (st_word),
      .st_full    (st_full),
      .fill_hit   (fill_valid && fill_line == LINE_W'(g)),
      .fill_spec  (fill_spec),
      .snp_hit    (snp_valid && snp_line == LINE_W'(g)),
      .snp_word   (snp_word),
      .snp_older  (snp_older),
      .snp_younger(snp_younger),
      .ev_hit     (ev_valid && ev_line == LINE_W'(g)),
      .valid_o    (line_valid[g]),
      .rd_any_o   (rd_any_vec[g]),
      .viol_o     (viol_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= quiet && (|viol_vec);
  end
  assign viol_req = viol_q;

  assign ev_req = ev_valid && quiet && rd_any_vec[ev_line];

  spec_stall_ctl u_stall (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_req (ev_req),
    .is_head(is_head),
    .stall_o(stall_req)
  );

  AST_VIOL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    viol_req |-> ($past(snp_valid) && $past(snp_older) && $past(quiet))); // R2
  AST_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |=> !viol_req); // R10

endmodule

// File: tb/sim_spec_line_tracker.sv
module sim_spec_line_tracker;
  localparam int NL = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] my_rank;
  logic       is_head, thr_start, thr_restart, thr_complete;
  logic       ld_valid, st_valid, st_full, fill_valid, fill_spec, snp_valid, ev_valid;
  logic [2:0] ld_line, st_line, fill_line, snp_line, ev_line, snp_rank;
  logic [1:0] ld_word, st_word, snp_word;
  logic [NL-1:0] line_valid;
  logic       viol_req, stall_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spec_line_tracker u0 (.*);

  // Row: op1,w1,op2,w2,op3,w3 (op 0 none,1 load,2 full store,3 partial store),
  // bus-store word, bus-store rank, expected violation. Line 0, my_rank = 2.
  localparam logic [16:0] TBL [8] = '{
    {2'd1,2'd1, 2'd0,2'd0, 2'd0,2'd0, 2'd1, 2'd1, 1'b1},
    {2'd1,2'd1, 2'd0,2'd0, 2'd0,2'd0, 2'd1, 2'd3, 1'b0},
    {2'd1,2'd1, 2'd0,2'd0, 2'd0,2'd0, 2'd0, 2'd1, 1'b0},
    {2'd2,2'd1, 2'd1,2'd1, 2'd0,2'd0, 2'd1, 2'd1, 1'b0},
    {2'd3,2'd1, 2'd1,2'd1, 2'd0,2'd0, 2'd1, 2'd1, 1'b1},
    {2'd1,2'd0, 2'd2,2'd2, 2'd1,2'd2, 2'd2, 2'd1, 1'b1},
    {2'd2,2'd2, 2'd1,2'd2, 2'd1,2'd0, 2'd0, 2'd1, 1'b1},
    {2'd1,2'd1, 2'd0,2'd0, 2'd0,2'd0, 2'd1, 2'd2, 1'b0}
  };

  function automatic string row_tag(input int i);
    case (i)
      0: return "R1/R2 older hit";
      1: return "R2 younger writer";
      2: return "R1 other word";
      3: return "R3 renamed word";
      4: return "R3 partial store";
      5: return "R4 store after read";
      6: return "R3 renamed plus read";
      default: return "R2 equal rank";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_ins();
    thr_start = 0; thr_restart = 0; thr_complete = 0;
    ld_valid = 0; st_valid = 0; st_full = 0; fill_valid = 0; fill_spec = 0;
    snp_valid = 0; ev_valid = 0;
    ld_line = 0; st_line = 0; fill_line = 0; snp_line = 0; ev_line = 0;
    ld_word = 0; st_word = 0; snp_word = 0; snp_rank = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_ins();
  endtask

  task automatic do_op(input logic [1:0] kind, input logic [2:0] ln, input logic [1:0] w);
    case (kind)
      2'd1: begin ld_valid = 1; ld_line = ln; ld_word = w; end
      2'd2: begin st_valid = 1; st_line = ln; st_word = w; st_full = 1; end
      2'd3: begin st_valid = 1; st_line = ln; st_word = w; st_full = 0; end
      default: ;
    endcase
    step();
  endtask

  task automatic fill(input logic [2:0] ln, input logic spec);
    fill_valid = 1; fill_line = ln; fill_spec = spec;
    step();
  endtask

  task automatic bus_store(input logic [2:0] ln, input logic [1:0] w, input logic [2:0] rk);
    snp_valid = 1; snp_line = ln; snp_word = w; snp_rank = rk;
    step();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    clear_ins();
    my_rank = 3'd2;
    is_head = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R11 reset valid", 32'(line_valid), 32'h0);
    check("R11 reset viol", 32'(viol_req), 32'h0);
    check("R11 reset stall", 32'(stall_req), 32'h0);

    fill(3'd0, 1'b0);
    check("R5 fill sets valid", 32'(line_valid), 32'h01);

    for (int i = 0; i < 8; i++) begin
      logic [16:0] e;
      e = TBL[i];
      thr_start = 1;
      step();
      do_op(e[16:15], 3'd0, e[14:13]);
      do_op(e[12:11], 3'd0, e[10:9]);
      do_op(e[8:7], 3'd0, e[6:5]);
      bus_store(3'd0, e[4:3], {1'b0, e[2:1]});
      check(row_tag(i), 32'(viol_req), 32'(e[0]));
      step();
      check({row_tag(i), " R2 one-cycle pulse"}, 32'(viol_req), 32'h0);
    end

    // Restart: line0 dirty, line1 clean, line2 speculative fill, line3 partial store
    fill(3'd1, 1'b0);
    fill(3'd2, 1'b1);
    fill(3'd3, 1'b0);
    do_op(2'd3, 3'd3, 2'd0);
    check("R5 before restart", 32'(line_valid), 32'h0F);
    thr_restart = 1;
    step();
    check("R6 restart drops modified", 32'(line_valid), 32'h02);

    // Deferred invalidation
    fill(3'd4, 1'b0);
    bus_store(3'd1, 2'd0, 3'd3);
    check("R7 line kept until complete", 32'(line_valid), 32'h12);
    check("R7 no violation from younger", 32'(viol_req), 32'h0);
    thr_complete = 1;
    step();
    check("R7 complete drops pre-invalidated", 32'(line_valid), 32'h10);

    // Gang clear of read bits
    do_op(2'd1, 3'd4, 2'd0);
    bus_store(3'd4, 2'd0, 3'd1);
    check("R1 control read bit set", 32'(viol_req), 32'h1);
    do_op(2'd1, 3'd4, 2'd0);
    thr_complete = 1;
    step();
    bus_store(3'd4, 2'd0, 3'd1);
    check("R8 complete clears reads", 32'(viol_req), 32'h0);
    do_op(2'd1, 3'd4, 2'd3);
    thr_start = 1;
    step();
    bus_store(3'd4, 2'd3, 3'd1);
    check("R8 start clears reads", 32'(viol_req), 32'h0);

    // Events during a gang command are ignored
    do_op(2'd1, 3'd4, 2'd1);
    thr_start = 1;
    snp_valid = 1; snp_line = 3'd4; snp_word = 2'd1; snp_rank = 3'd1;
    fill_valid = 1; fill_line = 3'd5;
    step();
    check("R10 no violation in command cycle", 32'(viol_req), 32'h0);
    check("R10 fill ignored in command cycle", 32'(line_valid), 32'h10);

    // Eviction stall
    fill(3'd6, 1'b0);
    do_op(2'd1, 3'd6, 2'd2);
    ev_valid = 1; ev_line = 3'd6;
    step();
    check("R9 stall raised", 32'(stall_req), 32'h1);
    check("R9 evicted line invalid", 32'(line_valid), 32'h10);
    repeat (3) step();
    check("R9 stall held while not head", 32'(stall_req), 32'h1);
    is_head = 1;
    step();
    is_head = 0;
    check("R9 stall released at head", 32'(stall_req), 32'h0);
    ev_valid = 1; ev_line = 3'd4;
    step();
    check("R9 clean eviction no stall", 32'(stall_req), 32'h0);
    check("R9 clean eviction invalidates", 32'(line_valid), 32'h00);
    bus_store(3'd6, 2'd2, 3'd1);
    check("R2 invalid line no violation", 32'(viol_req), 32'h0);

    summary();
    $finish;
  end
endmodule